// File: doc/BRIEF.md
# Disk Controller Programmed-I/O Front End

This block is the command and status side of a disk controller. A processor talks to it through single-word I/O instructions. Each instruction carries a device select, a 3-bit pulse field and a 2-bit subopcode. Pulse bit 0 asks for a skip test, bit 1 asks for a register read, and bit 2 asks for a register load. Any combination of the three may appear in one instruction.

The block holds two status words, the disk address, the memory address and the word count. It decides when a command starts, and it drives one interrupt request line. The transfer engine and the drives are outside the block. The engine receives a start pulse with the function and unit, and reports completion with error flags. Each drive reports its write lock, unsafe and active state, and raises attention when a seek completes.

Status word A holds the unit select in bits 17:15, the function in bits 14:12, the done-interrupt enable (octal 4000), the attention-interrupt enable (2000) and go (1000). It also holds error flags, a write-lock mirror (10), done (2) and a summary error (1). Status word B holds one attention bit per unit in bits 17:10, with unit u at bit 17-u, followed by error and drive-state bits.

Top module: `disk_pio_ctrl`

## Requirements
- R1: With pulse bit 0, the skip output goes high on device 0 as follows. Subopcode 0 skips on done, error or any attention bit. Subopcode 1 skips on any attention bit. Subopcode 2 skips on done. Subopcode 3 skips on error. Device 1 subopcode 1 always skips. Every other skip code does not skip.
- R2: With pulse bit 1, the data output is the data input ORed with a register. Device 0 subopcode 0 selects status A and subopcode 1 selects status B. Device 1 subopcode 1 selects the disk address, 2 the memory address and 3 the word count. Without a read, the data passes through unchanged.
- R3: Status A loads are device 1 with pulse bit 2. Subopcode 1 clears the bits in mask octal 777000 where the data is 0. Subopcode 2 sets the masked bits where the data is 1. Subopcode 3 replaces the masked field. Bits outside the mask are never written by these loads.
- R4: The summary error (A bit 0) is 1 exactly when one of these is set. In status A: write-lock error 400, nonexistent cylinder 200, nonexistent surface 100, nonexistent sector 40, header-not-found 20 or seek incomplete 4. In status B: unsafe 1000, programming error 400, end of pack 200, timing 100, format 40, write check 20, word parity 10 or long parity 4.
- R5: The interrupt output is high when error or done is set with A bit 11 on, or when any B bit 17:10 is set with A bit 10 on.
- R6: While busy, every load except the device clear sets the programming error (B octal 400) and changes nothing else.
- R7: Device 0 pulse bit 2 subopcode 1 clears header-not-found and done in status A, and clears B bits 8:2. Attention bits and the other A error flags remain.
- R8: After a status A load leaves go set, the command starts if the selected unit is not active. The block then sets busy and pulses the start output for one cycle with the function and unit. It clears that unit's attention bit, header-not-found and B bits 8:2. It also clears done, but only for functions other than 0, 3 and 4. If the unit is active, nothing starts.
- R9: A disk-address load (device 0 subopcode 0) stores the word. It sets A 40 when bits 3:0 are at least NUM_SECT, A 100 when bits 9:5 are at least NUM_SURF, and A 200 when bits 17:10 are at least NUM_CYL.
- R10: The word count is negative, and the transfer length output is 2^18 minus the count. A count of 0 gives 262144.
- R11: Engine completion clears busy, sets done, and ORs in its error flags. The A-side input bits 5..0 map to A 400, 200, 100, 40, 20 and 4. The B-side input bits 5..0 map to B 200, 100, 40, 20, 10 and 4. A drive's attention input sets B bit 17-u.
- R12: Device 1 pulse bit 2 subopcode 0 clears every register, busy and the attention bits, even while busy.
- R13: The per-unit state follows the unit selected in A bits 17:15. A bit 3 shows its write lock. B bit 9 shows unsafe, B bit 1 shows active, and B bit 0 shows unsafe or active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iot_valid_i | input | 1 | Instruction present this cycle |
| iot_dev_i | input | 1 | Device select (0 or 1) |
| iot_pulse_i | input | 3 | Skip, read, load request bits |
| iot_sub_i | input | 2 | Subopcode |
| iot_data_i | input | 18 | Accumulator data in |
| iot_data_o | output | 18 | Data in ORed with the read register |
| iot_skip_o | output | 1 | Skip condition met |
| irq_o | output | 1 | Interrupt request |
| busy_o | output | 1 | Command in progress |
| cmd_start_o | output | 1 | One-cycle start pulse to the engine |
| cmd_func_o | output | 3 | Latched function |
| cmd_unit_o | output | 3 | Latched unit |
| disk_addr_o | output | 18 | Disk address register |
| mem_addr_o | output | 18 | Memory address register |
| xfer_len_o | output | 19 | Transfer length from the word count |
| attn_set_i | input | 8 | Per-unit attention set pulses |
| drv_wlock_i | input | 8 | Per-unit write lock |
| drv_unsafe_i | input | 8 | Per-unit unsafe |
| drv_active_i | input | 8 | Per-unit active (seeking or transferring) |
| eng_done_i | input | 1 | Engine completion pulse |
| eng_err_a_i | input | 6 | Completion errors for status A |
| eng_err_b_i | input | 6 | Completion errors for status B |

## Verification
The bench builds the block with its default geometry of 10 sectors, 20 surfaces and 203 cylinders. Out-of-range addresses are therefore reachable with small literal values such as sector 10, surface 20 and cylinder 203. With these values, the walk across the in-range/out-of-range boundary of each address field fits in a handful of loads. The 18-bit word width lets the bench reach both the full-length transfer case (count 0) and the unit-to-attention-bit reversal with every unit index.

// File: rtl/disk_pio_pkg.sv
package disk_pio_pkg;
  localparam int WORD_W = 18;
  localparam int UNITS  = 8;
  localparam int UNIT_W = $clog2(UNITS);
  localparam int LEN_W  = WORD_W + 1;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [3:0] {
    CMD_NONE, CMD_LD_DA, CMD_CLR_STS, CMD_LD_MA, CMD_LD_WC,
    CMD_DEV_CLR, CMD_LDA_CLR, CMD_LDA_SET, CMD_LDA_FULL
  } cmd_e;

  localparam word_t STA_WR_MASK = 18'o777000;

  // status A bit positions
  localparam int A_UNIT_LSB = 15;
  localparam int A_FUNC_LSB = 12;
  localparam int A_IED  = 11;
  localparam int A_IEA  = 10;
  localparam int A_GO   = 9;
  localparam int A_WLK  = 3;
  localparam int A_SIK  = 2;
  localparam int A_DONE = 1;
  localparam int A_ERR  = 0;

  // status B bit positions
  localparam int B_ATTN_HI = 17;
  localparam int B_ATTN_LO = 10;
  localparam int B_UNSAFE  = 9;
  localparam int B_PGE     = 8;
  localparam int B_SEEK    = 1;
  localparam int B_NRDY    = 0;

  function automatic logic is_xfer_func(input logic [2:0] f);
    return !(f == 3'd0 || f == 3'd3 || f == 3'd4);
  endfunction
endpackage

// File: rtl/disk_pio_decode.sv
module disk_pio_decode
  import disk_pio_pkg::*;
(
  input  logic       valid_i,
  input  logic       dev_i,
  input  logic [2:0] pulse_i,
  input  logic [1:0] sub_i,
  output cmd_e       cmd_o
);
  always_comb begin
    cmd_o = CMD_NONE;
    if (valid_i && pulse_i[2]) begin
      if (!dev_i) begin
        case (sub_i)
          2'd0:    cmd_o = CMD_LD_DA;
          2'd1:    cmd_o = CMD_CLR_STS;
          2'd2:    cmd_o = CMD_LD_MA;
          default: cmd_o = CMD_LD_WC;
        endcase
      end else begin
        case (sub_i)
          2'd0:    cmd_o = CMD_DEV_CLR;
          2'd1:    cmd_o = CMD_LDA_CLR;
          2'd2:    cmd_o = CMD_LDA_SET;
          default: cmd_o = CMD_LDA_FULL;
        endcase
      end
    end
  end
endmodule

// File: rtl/disk_pio_addr.sv
module disk_pio_addr
  import disk_pio_pkg::*;
#(
  parameter int NUM_SECT = 10,
  parameter int NUM_SURF = 20,
  parameter int NUM_CYL  = 203
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_e             cmd_i,
  input  logic             accept_i,
  input  word_t            data_i,
  output word_t            da_o,
  output word_t            ma_o,
  output word_t            wc_o,
  output logic [LEN_W-1:0] xfer_len_o,
  output logic [2:0]       range_err_o
);
  localparam int SECT_LSB = 0;
  localparam int SECT_W   = 4;
  localparam int SURF_LSB = 5;
  localparam int SURF_W   = 5;
  localparam int CYL_LSB  = 10;
  localparam int CYL_W    = 8;
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(1) << WORD_W;

  word_t da_q, ma_q, wc_q;

  // {cylinder, surface, sector} out of range
  assign range_err_o = {
    int'(data_i[CYL_LSB  +: CYL_W])  >= NUM_CYL,
    int'(data_i[SURF_LSB +: SURF_W]) >= NUM_SURF,
    int'(data_i[SECT_LSB +: SECT_W]) >= NUM_SECT
  };

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      da_q <= '0;
      ma_q <= '0;
      wc_q <= '0;
    end else if (cmd_i == CMD_DEV_CLR) begin
      da_q <= '0;
      ma_q <= '0;
      wc_q <= '0;
    end else if (accept_i) begin
      if (cmd_i == CMD_LD_DA) da_q <= data_i;
      if (cmd_i == CMD_LD_MA) ma_q <= data_i;
      if (cmd_i == CMD_LD_WC) wc_q <= data_i;
    end
  end

  assign da_o       = da_q;
  assign ma_o       = ma_q;
  assign wc_o       = wc_q;
  assign xfer_len_o = FULL_LEN - {1'b0, wc_q};
endmodule

// File: rtl/disk_pio_status.sv
module disk_pio_status
  import disk_pio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  word_t             data_i,
  input  logic [2:0]        range_err_i,
  input  logic [UNITS-1:0]  attn_set_i,
  input  logic [UNITS-1:0]  drv_wlock_i,
  input  logic [UNITS-1:0]  drv_unsafe_i,
  input  logic [UNITS-1:0]  drv_active_i,
  input  logic              eng_done_i,
  input  logic [5:0]        eng_err_a_i,
  input  logic [5:0]        eng_err_b_i,
  output word_t             sta_a_o,
  output word_t             sta_b_o,
  output logic              busy_o,
  output logic              accept_o,
  output logic              irq_o,
  output logic              start_o,
  output logic [2:0]        func_o,
  output logic [UNIT_W-1:0] unit_o
);
  word_t             a_q, b_q, a_n, b_n;
  logic              busy_q, busy_n, start_q, start_n;
  logic [2:0]        func_q, func_n;
  logic [UNIT_W-1:0] unit_q, unit_n, sel_unit, new_unit;
  logic              blocked, is_lda, err;

  assign blocked  = busy_q && cmd_i != CMD_NONE && cmd_i != CMD_DEV_CLR;
  assign is_lda   = cmd_i inside {CMD_LDA_CLR, CMD_LDA_SET, CMD_LDA_FULL};
  assign new_unit = a_n[A_UNIT_LSB +: UNIT_W];

  always_comb begin
    a_n     = a_q;
    b_n     = b_q;
    busy_n  = busy_q;
    start_n = 1'b0;
    func_n  = func_q;
    unit_n  = unit_q;
    if (eng_done_i) begin
      busy_n     = 1'b0;
      a_n[A_DONE] = 1'b1;
      a_n[8:4]   = a_n[8:4] | eng_err_a_i[5:1];
      a_n[A_SIK] = a_n[A_SIK] | eng_err_a_i[0];
      b_n[7:2]   = b_n[7:2] | eng_err_b_i;
    end
    for (int u = 0; u < UNITS; u++)
      if (attn_set_i[u]) b_n[B_ATTN_HI-u] = 1'b1;
    if (blocked) begin
      b_n[B_PGE] = 1'b1;
    end else begin
      case (cmd_i)
        CMD_LD_DA:    a_n[7:5] = a_n[7:5] | range_err_i;
        CMD_CLR_STS: begin
          a_n[4]      = 1'b0;
          a_n[A_DONE] = 1'b0;
          b_n[8:2]    = '0;
        end
        CMD_LDA_CLR:  a_n = a_n & (data_i | ~STA_WR_MASK);
        CMD_LDA_SET:  a_n = a_n | (data_i & STA_WR_MASK);
        CMD_LDA_FULL: a_n = (a_n & ~STA_WR_MASK) | (data_i & STA_WR_MASK);
        default: ;
      endcase
      if (is_lda && a_n[A_GO] && !drv_active_i[new_unit]) begin
        busy_n   = 1'b1;
        start_n  = 1'b1;
        func_n   = a_n[A_FUNC_LSB +: 3];
        unit_n   = new_unit;
        a_n[4]   = 1'b0;
        b_n[8:2] = '0;
        b_n[B_ATTN_HI-int'(new_unit)] = 1'b0;
        if (is_xfer_func(func_n)) a_n[A_DONE] = 1'b0;
      end
    end
    if (cmd_i == CMD_DEV_CLR) begin
      a_n     = '0;
      b_n     = '0;
      busy_n  = 1'b0;
      start_n = 1'b0;
      func_n  = '0;
      unit_n  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q     <= '0;
      b_q     <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      func_q  <= '0;
      unit_q  <= '0;
    end else begin
      a_q     <= a_n;
      b_q     <= b_n;
      busy_q  <= busy_n;
      start_q <= start_n;
      func_q  <= func_n;
      unit_q  <= unit_n;
    end
  end

  // per-unit fields are live views of the selected drive
  assign sel_unit = a_q[A_UNIT_LSB +: UNIT_W];
  always_comb begin
    sta_b_o           = b_q;
    sta_b_o[B_UNSAFE] = drv_unsafe_i[sel_unit];
    sta_b_o[B_SEEK]   = drv_active_i[sel_unit];
    sta_b_o[B_NRDY]   = drv_unsafe_i[sel_unit] | drv_active_i[sel_unit];
    err = (|a_q[8:4]) | a_q[A_SIK] | (|sta_b_o[B_UNSAFE:2]);
    sta_a_o        = a_q;
    sta_a_o[A_WLK] = drv_wlock_i[sel_unit];
    sta_a_o[A_ERR] = err;
  end

  assign irq_o    = ((err | a_q[A_DONE]) & a_q[A_IED]) |
                    ((|b_q[B_ATTN_HI:B_ATTN_LO]) & a_q[A_IEA]);
  assign busy_o   = busy_q;
  assign accept_o = !busy_q;
  assign start_o  = start_q;
  assign func_o   = func_q;
  assign unit_o   = unit_q;
endmodule

// File: rtl/disk_pio_ctrl.sv
module disk_pio_ctrl
  import disk_pio_pkg::*;
#(
  parameter int NUM_SECT = 10,
  parameter int NUM_SURF = 20,
  parameter int NUM_CYL  = 203
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        iot_valid_i,
  input  logic        iot_dev_i,
  input  logic [2:0]  iot_pulse_i,
  input  logic [1:0]  iot_sub_i,
  input  logic [17:0] iot_data_i,
  output logic [17:0] iot_data_o,
  output logic        iot_skip_o,
  output logic        irq_o,
  output logic        busy_o,
  output logic        cmd_start_o,
  output logic [2:0]  cmd_func_o,
  output logic [2:0]  cmd_unit_o,
  output logic [17:0] disk_addr_o,
  output logic [17:0] mem_addr_o,
  output logic [18:0] xfer_len_o,
  input  logic [7:0]  attn_set_i,
  input  logic [7:0]  drv_wlock_i,
  input  logic [7:0]  drv_unsafe_i,
  input  logic [7:0]  drv_active_i,
  input  logic        eng_done_i,
  input  logic [5:0]  eng_err_a_i,
  input  logic [5:0]  eng_err_b_i
);
  cmd_e       cmd;
  word_t      sta_a_w, sta_b_w, da_w, ma_w, wc_w, rd_w;
  logic [2:0] range_err;
  logic       accept, any_attn;

  disk_pio_decode u_dec (
    .valid_i(iot_valid_i), .dev_i(iot_dev_i), .pulse_i(iot_pulse_i),
    .sub_i(iot_sub_i), .cmd_o(cmd)
  );

  disk_pio_addr #(.NUM_SECT(NUM_SECT), .NUM_SURF(NUM_SURF), .NUM_CYL(NUM_CYL)) u_addr (
    .clk_i, .rst_ni, .cmd_i(cmd), .accept_i(accept), .data_i(iot_data_i),
    .da_o(da_w), .ma_o(ma_w), .wc_o(wc_w), .xfer_len_o, .range_err_o(range_err)
  );

  disk_pio_status u_sta (
    .clk_i, .rst_ni, .cmd_i(cmd), .data_i(iot_data_i), .range_err_i(range_err),
    .attn_set_i, .drv_wlock_i, .drv_unsafe_i, .drv_active_i,
    .eng_done_i, .eng_err_a_i, .eng_err_b_i,
    .sta_a_o(sta_a_w), .sta_b_o(sta_b_w), .busy_o, .accept_o(accept), .irq_o,
    .start_o(cmd_start_o), .func_o(cmd_func_o), .unit_o(cmd_unit_o)
  );

  assign any_attn = |sta_b_w[B_ATTN_HI:B_ATTN_LO];

  always_comb begin
    rd_w = '0;
    if (iot_valid_i && iot_pulse_i[1]) begin
      if (!iot_dev_i) begin
        if (iot_sub_i == 2'd0) rd_w = sta_a_w;
        if (iot_sub_i == 2'd1) rd_w = sta_b_w;
      end else begin
        case (iot_sub_i)
          2'd1:    rd_w = da_w;
          2'd2:    rd_w = ma_w;
          2'd3:    rd_w = wc_w;
          default: rd_w = '0;
        endcase
      end
    end
  end

  always_comb begin
    iot_skip_o = 1'b0;
    if (iot_valid_i && iot_pulse_i[0]) begin
      if (!iot_dev_i) begin
        case (iot_sub_i)
          2'd0:    iot_skip_o = sta_a_w[A_DONE] | sta_a_w[A_ERR] | any_attn;
          2'd1:    iot_skip_o = any_attn;
          2'd2:    iot_skip_o = sta_a_w[A_DONE];
          default: iot_skip_o = sta_a_w[A_ERR];
        endcase
      end else begin
        iot_skip_o = (iot_sub_i == 2'd1);
      end
    end
  end

  assign iot_data_o  = iot_data_i | rd_w;
  assign disk_addr_o = da_w;
  assign mem_addr_o  = ma_w;
endmodule

// File: rtl/disk_pio_ctrl_chk.sv
module disk_pio_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        iot_valid_i,
  input logic        iot_dev_i,
  input logic [2:0]  iot_pulse_i,
  input logic [1:0]  iot_sub_i,
  input logic        busy_o,
  input logic        irq_o,
  input logic        cmd_start_o,
  input logic        eng_done_i,
  input logic [17:0] sta_a,
  input logic [17:0] sta_b,
  input logic [17:0] mem_addr_o
);
  logic any_load, dev_clr;
  assign any_load = iot_valid_i && iot_pulse_i[2];
  assign dev_clr  = any_load && iot_dev_i && iot_sub_i == 2'd0;

  p_busy_load_pge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && any_load && !dev_clr |=> sta_b[8]);

  p_busy_ma_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && any_load && !iot_dev_i && iot_sub_i == 2'd2 |=> $stable(mem_addr_o));

  p_start_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_start_o |-> busy_o);

  p_dev_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_clr |=> !busy_o && !irq_o);

  p_eng_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done_i && !any_load |=> sta_a[1] && !busy_o);

  p_irq_enable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sta_a[11] || sta_a[10]));
endmodule

bind disk_pio_ctrl disk_pio_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .iot_valid_i(iot_valid_i), .iot_dev_i(iot_dev_i),
  .iot_pulse_i(iot_pulse_i), .iot_sub_i(iot_sub_i), .busy_o(busy_o), .irq_o(irq_o),
  .cmd_start_o(cmd_start_o), .eng_done_i(eng_done_i), .sta_a(sta_a_w), .sta_b(sta_b_w),
  .mem_addr_o(mem_addr_o)
);

// File: tb/disk_pio_ctrl_test.sv
module disk_pio_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        iot_valid_i = 1'b0, iot_dev_i = 1'b0;
  logic [2:0]  iot_pulse_i = '0;
  logic [1:0]  iot_sub_i = '0;
  logic [17:0] iot_data_i = '0;
  logic [17:0] iot_data_o, disk_addr_o, mem_addr_o;
  logic        iot_skip_o, irq_o, busy_o, cmd_start_o;
  logic [2:0]  cmd_func_o, cmd_unit_o;
  logic [18:0] xfer_len_o;
  logic [7:0]  attn_set_i = '0, drv_wlock_i = '0, drv_unsafe_i = '0, drv_active_i = '0;
  logic        eng_done_i = 1'b0;
  logic [5:0]  eng_err_a_i = '0, eng_err_b_i = '0;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [17:0] rd_data;
  logic        rd_skip;

  always #(CLK_PERIOD/2) clk = ~clk;

  disk_pio_ctrl uut (
    .clk_i(clk), .rst_ni, .iot_valid_i, .iot_dev_i, .iot_pulse_i, .iot_sub_i,
    .iot_data_i, .iot_data_o, .iot_skip_o, .irq_o, .busy_o, .cmd_start_o,
    .cmd_func_o, .cmd_unit_o, .disk_addr_o, .mem_addr_o, .xfer_len_o,
    .attn_set_i, .drv_wlock_i, .drv_unsafe_i, .drv_active_i,
    .eng_done_i, .eng_err_a_i, .eng_err_b_i
  );

  // {dev, pulse, sub, data in, expected data out, expected skip}
  localparam logic [42:0] VEC [NV] = '{
    {1'b0, 3'd2, 2'd0, 18'o000000, 18'o000000, 1'b0},
    {1'b1, 3'd4, 2'd3, 18'o204000, 18'o204000, 1'b0},
    {1'b0, 3'd2, 2'd0, 18'o000000, 18'o204000, 1'b0},
    {1'b1, 3'd4, 2'd1, 18'o773777, 18'o773777, 1'b0},
    {1'b0, 3'd2, 2'd0, 18'o000000, 18'o200000, 1'b0},
    {1'b1, 3'd4, 2'd2, 18'o002002, 18'o002002, 1'b0},
    {1'b0, 3'd2, 2'd0, 18'o000000, 18'o202000, 1'b0},
    {1'b0, 3'd1, 2'd0, 18'o000000, 18'o000000, 1'b0},
    {1'b1, 3'd1, 2'd1, 18'o000000, 18'o000000, 1'b1},
    {1'b0, 3'd4, 2'd0, 18'o012147, 18'o012147, 1'b0},
    {1'b1, 3'd2, 2'd1, 18'o000000, 18'o012147, 1'b0},
    {1'b0, 3'd4, 2'd2, 18'o001000, 18'o001000, 1'b0},
    {1'b1, 3'd2, 2'd2, 18'o000000, 18'o001000, 1'b0},
    {1'b0, 3'd4, 2'd3, 18'o777400, 18'o777400, 1'b0},
    {1'b1, 3'd2, 2'd3, 18'o000000, 18'o777400, 1'b0},
    {1'b0, 3'd2, 2'd0, 18'o000001, 18'o202001, 1'b0},
    {1'b0, 3'd2, 2'd1, 18'o000000, 18'o000000, 1'b0},
    {1'b0, 3'd3, 2'd0, 18'o000000, 18'o202000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
    end
  endtask

  task automatic iot(input logic dev, input logic [2:0] p, input logic [1:0] s,
                     input logic [17:0] d);
    @(negedge clk);
    iot_dev_i = dev; iot_pulse_i = p; iot_sub_i = s; iot_data_i = d; iot_valid_i = 1'b1;
    #1;
    rd_data = iot_data_o;
    rd_skip = iot_skip_o;
    @(negedge clk);
    iot_valid_i = 1'b0; iot_pulse_i = '0; iot_data_i = '0;
    #1;
  endtask

  task automatic rd_a(input string req, input logic [17:0] exp);
    iot(1'b0, 3'd2, 2'd0, 18'o0); chk(req, rd_data, exp);
  endtask
  task automatic rd_b(input string req, input logic [17:0] exp);
    iot(1'b0, 3'd2, 2'd1, 18'o0); chk(req, rd_data, exp);
  endtask

  task automatic eng(input logic [5:0] ea, input logic [5:0] eb);
    @(negedge clk);
    eng_done_i = 1'b1; eng_err_a_i = ea; eng_err_b_i = eb;
    @(negedge clk);
    eng_done_i = 1'b0; eng_err_a_i = '0; eng_err_b_i = '0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("reset irq", irq_o, 0);
    chk("reset busy", busy_o, 0);
    chk("reset xfer_len R10", xfer_len_o, 19'd262144);

    // table walk (R1 R2 R3 R9)
    for (int i = 0; i < NV; i++) begin
      iot(VEC[i][42], VEC[i][41:39], VEC[i][38:37], VEC[i][36:19]);
      chk($sformatf("R2/R3 table data %0d", i), rd_data, VEC[i][18:1]);
      chk($sformatf("R1 table skip %0d", i), rd_skip, VEC[i][0]);
    end
    chk("R10 len 256", xfer_len_o, 19'd256);

    // attention on unit 2 with attention-interrupt enable (R11 R5)
    @(negedge clk); attn_set_i = 8'b0000_0100; @(negedge clk); attn_set_i = '0; #1;
    chk("R5 attn irq", irq_o, 1);
    rd_b("R11 attn bit", 18'o100000);
    iot(1'b0, 3'd1, 2'd1, 18'o0); chk("R1 attn skip", rd_skip, 1);
    iot(1'b0, 3'd4, 2'd1, 18'o0);
    rd_b("R7 attn kept", 18'o100000);

    // go: unit 2 read function with done-interrupt enable (R8)
    iot(1'b1, 3'd4, 2'd3, 18'o215000);
    chk("R8 start", cmd_start_o, 1);
    chk("R8 busy", busy_o, 1);
    chk("R8 func", cmd_func_o, 1);
    chk("R8 unit", cmd_unit_o, 2);
    #(CLK_PERIOD); chk("R8 start one cycle", cmd_start_o, 0);
    rd_b("R8 attn cleared", 18'o0);
    rd_a("R8 A after go", 18'o215000);
    chk("R5 irq off", irq_o, 0);

    // load while busy (R6 R4)
    iot(1'b0, 3'd4, 2'd2, 18'o000777);
    iot(1'b1, 3'd2, 2'd2, 18'o0); chk("R6 MA kept", rd_data, 18'o001000);
    rd_b("R6 pge", 18'o000400);
    rd_a("R4 err from pge", 18'o215001);
    chk("R5 err irq", irq_o, 1);

    // engine completion with write-check error (R11)
    eng(6'b0, 6'b000100);
    chk("R11 busy clr", busy_o, 0);
    rd_a("R11 done", 18'o215003);
    rd_b("R11 B err", 18'o000420);

    // clear status (R7)
    iot(1'b0, 3'd4, 2'd1, 18'o0);
    rd_a("R7 A", 18'o215000);
    rd_b("R7 B", 18'o0);
    chk("R7 irq", irq_o, 0);

    // address range checks (R9)
    iot(1'b0, 3'd4, 2'd0, 18'o000012);
    rd_a("R9 sector", 18'o215041);
    chk("R5 irq range", irq_o, 1);
    iot(1'b0, 3'd4, 2'd0, 18'o627200);
    rd_a("R9 surf cyl", 18'o215341);

    // device clear (R12)
    iot(1'b1, 3'd4, 2'd0, 18'o0);
    rd_a("R12 A", 18'o0);
    chk("R12 irq", irq_o, 0);
    iot(1'b1, 3'd2, 2'd1, 18'o0); chk("R12 DA", rd_data, 0);
    chk("R10 len full", xfer_len_o, 19'd262144);
    iot(1'b1, 3'd4, 2'd3, 18'o041000);
    chk("R8 seek busy", busy_o, 1);
    chk("R8 seek func", cmd_func_o, 4);
    iot(1'b1, 3'd4, 2'd0, 18'o0);
    chk("R12 busy clr", busy_o, 0);
    rd_a("R12 A busy", 18'o0);

    // per-unit dynamic state (R13)
    drv_wlock_i[0] = 1'b1; #1;
    rd_a("R13 wlock", 18'o000010);
    drv_unsafe_i[0] = 1'b1; #1;
    rd_b("R13 unsafe", 18'o001001);
    rd_a("R4 unsafe err", 18'o000011);
    drv_active_i[0] = 1'b1; #1;
    rd_b("R13 active", 18'o001003);
    drv_unsafe_i[0] = 1'b0; #1;
    rd_b("R13 active only", 18'o000003);
    drv_active_i[1] = 1'b1; #1;
    rd_b("R13 other unit", 18'o000003);

    // go refused on active unit (R8)
    iot(1'b1, 3'd4, 2'd3, 18'o041000);
    chk("R8 refused start", cmd_start_o, 0);
    chk("R8 refused busy", busy_o, 0);
    rd_a("R8 refused A", 18'o041010);
    drv_wlock_i = '0; drv_active_i = '0; #1;

    // engine A error, skip codes (R11 R1)
    eng(6'b100000, 6'b0);
    rd_a("R11 A err", 18'o041403);
    iot(1'b0, 3'd1, 2'd0, 18'o0); chk("R1 any", rd_skip, 1);
    iot(1'b0, 3'd1, 2'd2, 18'o0); chk("R1 done", rd_skip, 1);
    iot(1'b0, 3'd1, 2'd3, 18'o0); chk("R1 err", rd_skip, 1);
    iot(1'b0, 3'd1, 2'd1, 18'o0); chk("R1 attn none", rd_skip, 0);
    iot(1'b1, 3'd1, 2'd2, 18'o0); chk("R1 dev1 other", rd_skip, 0);
    chk("R5 no enable", irq_o, 0);

    // set-mode enable restarts the pending seek; done is kept (R5 R8)
    iot(1'b1, 3'd4, 2'd2, 18'o004000);
    chk("R8 seek keeps done busy", busy_o, 1);
    chk("R5 done irq", irq_o, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule